// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the memory-mapped register side of a platform-level interrupt controller. A 32-bit request/response bus reaches it with a byte address, write data and a read/write flag. Each response carries read data and an error flag. The block holds three sets of registers and drives them out as flat vectors toward the arbiter core:

- one priority per interrupt source;
- one set of enable words per context;
- one threshold per context.

The live pending vector from the core can be read but not written. Each context has a claim/complete word. Reading it produces a one-cycle claim strobe and returns the winning ID that the arbiter presents. Writing it produces a completion strobe that carries the written ID.

Sources are numbered 1..NSRC, and ID 0 means "no interrupt". The region bases, the two per-context strides, the source count, the context count and the number of priority levels are all parameters. Elaboration rejects a stride that is not a power of two.

Both bus directions use valid/ready. A request is accepted when `req_valid` and `req_ready` are high at the same clock edge. The response appears on the next cycle and holds steady until `rsp_ready` is seen. Only one response can be outstanding, so `req_ready` is low while an unconsumed response is held. The claim and completion strobes rise in the cycle where the request is accepted, so the arbiter retires the claimed source on that same edge.

Top module: `intc_reg_front`

## Requirements
- R1: `req_ready` is low exactly while a response is held with `rsp_ready` low. An accepted request gives `rsp_valid` on the next cycle. A held response keeps its data and error flag unchanged until it is taken.
- R2: An access whose address has either of its two low bits set returns error with read data 0. It changes no register and raises no strobe.
- R3: The priority word at byte PRIO_BASE+4k belongs to source k+1, for k in 0..NSRC-1. A write stores only the low PRIO_W bits. A read returns the stored value, and `prio_o[k*PRIO_W +: PRIO_W]` carries it.
- R4: Pending word w at PEND_BASE+4w reads bit b as the pending state of source 32w+b. Bit 0 of word 0 and any bit above source NSRC read as 0. The word count is WORDS=ceil((NSRC+1)/32).
- R5: A write to the pending region returns error and changes nothing.
- R6: Enable word w of context c is at EN_BASE+c*EN_STRIDE+4w, with bit b meaning source 32w+b. Bits that name no source are stored as 0. `en_o[c*NSRC+s-1]` is the enable of source s in context c.
- R7: An enable word index at or beyond WORDS inside a context's stride is unmapped: reads return 0 with error, and writes return error and are ignored.
- R8: The threshold of context c is at CTX_BASE+c*CTX_STRIDE. A write stores the value only if it is no greater than NUM_PRIO. A larger value is dropped with no error. A read returns the threshold, and `thr_o[c*TH_W +: TH_W]` carries it.
- R9: A read of CTX_BASE+c*CTX_STRIDE+4 raises `claim_o[c]` for the accept cycle only. The response data is the `claim_id_i` slice of context c sampled at that edge.
- R10: A write of value v to that same word raises `complete_o[c]` for the accept cycle, with `complete_id_o`=v, when 1<=v<=NSRC. Any other value gives no strobe and no error.
- R11: Any other address returns error. Reads give 0 and writes change nothing.
- R12: After reset all priorities, enables and thresholds are 0, no response is held and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access error |
| pend_i | input | NSRC | Pending state, bit s-1 = source s |
| claim_id_i | input | NCTX*ID_W | Arbiter winning ID per context |
| claim_o | output | NCTX | Claim strobe per context |
| complete_o | output | NCTX | Completion strobe per context |
| complete_id_o | output | ID_W | ID being completed |
| prio_o | output | NSRC*PRIO_W | Source priorities |
| en_o | output | NCTX*NSRC | Per-context enables |
| thr_o | output | NCTX*TH_W | Per-context thresholds |

## Verification
The bench builds the block with 40 sources, 2 contexts, 7 priority levels, an enable stride of 0x80 and a context stride of 0x1000. With 40 sources the enable and pending words number two, and the last word is only partly populated. This exercises the masking of bits beyond source 40, of source 0, and of the out-of-range word index 2 inside each stride. Two contexts are enough to show that strided addressing picks the right context. Seven levels place the threshold rejection boundary between values 7 and 8.

// File: rtl/intc_reg_pkg.sv
package intc_reg_pkg;

  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_PRIO  = 3'd1,
    RG_PEND  = 3'd2,
    RG_EN    = 3'd3,
    RG_THR   = 3'd4,
    RG_CLAIM = 3'd5
  } region_e;

  typedef struct packed {
    region_e     region;
    logic        misaligned;
    logic [15:0] idx;
    logic [15:0] ctx;
  } dec_t;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // bits of enable/pending word w that name a real source (1..nsrc)
  function automatic logic [31:0] src_word_mask(input int w, input int nsrc);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) begin
      m[b] = ((32 * w + b) >= 1) && ((32 * w + b) <= nsrc);
    end
    return m;
  endfunction

endpackage

// File: rtl/intc_addr_decode.sv
module intc_addr_decode
  import intc_reg_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          NSRC       = 40,
  parameter int          NCTX       = 2,
  parameter int unsigned PRIO_BASE  = 32'h0000,
  parameter int unsigned PEND_BASE  = 32'h1000,
  parameter int unsigned EN_BASE    = 32'h2000,
  parameter int unsigned EN_STRIDE  = 32'h80,
  parameter int unsigned CTX_BASE   = 32'h10_0000,
  parameter int unsigned CTX_STRIDE = 32'h1000
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int          WORDS     = (NSRC + 32) / 32;
  localparam int unsigned PRIO_SIZE = NSRC * 4;
  localparam int unsigned PEND_SIZE = WORDS * 4;
  localparam int unsigned EN_SIZE   = NCTX * EN_STRIDE;
  localparam int unsigned CTX_SIZE  = NCTX * CTX_STRIDE;
  localparam int          EN_SH     = $clog2(EN_STRIDE);
  localparam int          CTX_SH    = $clog2(CTX_STRIDE);

  logic [31:0] a, o_prio, o_pend, o_en, o_ctx, t_idx, t_ctx, t_sub;

  always_comb begin
    a = '0;
    a[ADDR_W-1:0] = addr;
    o_prio = a - PRIO_BASE;
    o_pend = a - PEND_BASE;
    o_en   = a - EN_BASE;
    o_ctx  = a - CTX_BASE;
    t_idx  = '0;
    t_ctx  = '0;
    t_sub  = '0;
    dec            = '0;
    dec.region     = RG_NONE;
    dec.misaligned = |a[1:0];
    if (!dec.misaligned) begin
      if (o_prio < PRIO_SIZE) begin
        dec.region = RG_PRIO;
        t_idx      = o_prio >> 2;
      end else if (o_pend < PEND_SIZE) begin
        dec.region = RG_PEND;
        t_idx      = o_pend >> 2;
      end else if (o_en < EN_SIZE) begin
        t_ctx = o_en >> EN_SH;
        t_idx = (o_en & (EN_STRIDE - 1)) >> 2;
        if (t_idx < WORDS) dec.region = RG_EN;
      end else if (o_ctx < CTX_SIZE) begin
        t_ctx = o_ctx >> CTX_SH;
        t_sub = o_ctx & (CTX_STRIDE - 1);
        if (t_sub == 32'd0)      dec.region = RG_THR;
        else if (t_sub == 32'd4) dec.region = RG_CLAIM;
      end
    end
    dec.idx = t_idx[15:0];
    dec.ctx = t_ctx[15:0];
  end
endmodule

// File: rtl/intc_reg_store.sv
module intc_reg_store
  import intc_reg_pkg::*;
#(
  parameter int          NSRC     = 40,
  parameter int          NCTX     = 2,
  parameter int          PRIO_W   = 3,
  parameter int unsigned NUM_PRIO = 7,
  parameter int          TH_W     = 3,
  localparam int         WORDS    = (NSRC + 32) / 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  dec_t                      dec,
  input  logic [31:0]               wdata,
  output logic [NSRC*PRIO_W-1:0]    prio_q,
  output logic [NCTX*WORDS*32-1:0]  en_words_q,
  output logic [NCTX*TH_W-1:0]      thr_q
);
  for (genvar k = 0; k < NSRC; k++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q[k*PRIO_W +: PRIO_W] <= '0;
      else if (wr && dec.region == RG_PRIO && dec.idx == 16'(k))
        prio_q[k*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
    end
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam logic [31:0] MASK = src_word_mask(w, NSRC);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_words_q[(c*WORDS+w)*32 +: 32] <= '0;
        else if (wr && dec.region == RG_EN && dec.ctx == 16'(c) && dec.idx == 16'(w))
          en_words_q[(c*WORDS+w)*32 +: 32] <= wdata & MASK;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q[c*TH_W +: TH_W] <= '0;
      else if (wr && dec.region == RG_THR && dec.ctx == 16'(c) && wdata <= NUM_PRIO)
        thr_q[c*TH_W +: TH_W] <= wdata[TH_W-1:0];
    end
  end
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
  import intc_reg_pkg::*;
#(
  parameter int  NSRC   = 40,
  parameter int  NCTX   = 2,
  parameter int  PRIO_W = 3,
  parameter int  TH_W   = 3,
  parameter int  ID_W   = 6,
  localparam int WORDS  = (NSRC + 32) / 32
) (
  input  dec_t                     dec,
  input  logic                     wr,
  input  logic [NSRC*PRIO_W-1:0]   prio_q,
  input  logic [NCTX*WORDS*32-1:0] en_words_q,
  input  logic [NCTX*TH_W-1:0]     thr_q,
  input  logic [NSRC-1:0]          pend_i,
  input  logic [NCTX*ID_W-1:0]     claim_id_i,
  output logic [31:0]              rdata,
  output logic                     err
);
  logic [WORDS*32-1:0] pview;

  always_comb begin
    pview = '0;
    pview[NSRC:1] = pend_i;
  end

  always_comb begin
    err   = dec.misaligned || dec.region == RG_NONE || (wr && dec.region == RG_PEND);
    rdata = '0;
    if (!err && !wr) begin
      unique case (dec.region)
        RG_PRIO:
          for (int k = 0; k < NSRC; k++)
            if (dec.idx == 16'(k)) rdata[PRIO_W-1:0] = prio_q[k*PRIO_W +: PRIO_W];
        RG_PEND:
          for (int w = 0; w < WORDS; w++)
            if (dec.idx == 16'(w)) rdata = pview[w*32 +: 32];
        RG_EN:
          for (int c = 0; c < NCTX; c++)
            for (int w = 0; w < WORDS; w++)
              if (dec.ctx == 16'(c) && dec.idx == 16'(w))
                rdata = en_words_q[(c*WORDS+w)*32 +: 32];
        RG_THR:
          for (int c = 0; c < NCTX; c++)
            if (dec.ctx == 16'(c)) rdata[TH_W-1:0] = thr_q[c*TH_W +: TH_W];
        RG_CLAIM:
          for (int c = 0; c < NCTX; c++)
            if (dec.ctx == 16'(c)) rdata[ID_W-1:0] = claim_id_i[c*ID_W +: ID_W];
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_reg_front.sv
module intc_reg_front
  import intc_reg_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          NSRC       = 40,
  parameter int          NCTX       = 2,
  parameter int          PRIO_W     = 3,
  parameter int unsigned NUM_PRIO   = 7,
  parameter int unsigned PRIO_BASE  = 32'h0000,
  parameter int unsigned PEND_BASE  = 32'h1000,
  parameter int unsigned EN_BASE    = 32'h2000,
  parameter int unsigned EN_STRIDE  = 32'h80,
  parameter int unsigned CTX_BASE   = 32'h10_0000,
  parameter int unsigned CTX_STRIDE = 32'h1000,
  localparam int         ID_W       = $clog2(NSRC + 1),
  localparam int         TH_W       = $clog2(NUM_PRIO + 1),
  localparam int         WORDS      = (NSRC + 32) / 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [31:0]             rsp_rdata,
  output logic                    rsp_err,
  input  logic [NSRC-1:0]         pend_i,
  input  logic [NCTX*ID_W-1:0]    claim_id_i,
  output logic [NCTX-1:0]         claim_o,
  output logic [NCTX-1:0]         complete_o,
  output logic [ID_W-1:0]         complete_id_o,
  output logic [NSRC*PRIO_W-1:0]  prio_o,
  output logic [NCTX*NSRC-1:0]    en_o,
  output logic [NCTX*TH_W-1:0]    thr_o
);
  if (!is_pow2(EN_STRIDE) || EN_STRIDE < WORDS * 4) begin : g_bad_en_stride
    $error("enable stride must be a power of two covering all enable words");
  end
  if (!is_pow2(CTX_STRIDE) || CTX_STRIDE < 8) begin : g_bad_ctx_stride
    $error("context stride must be a power of two of at least 8 bytes");
  end

  dec_t                     dec;
  logic                     acc;
  logic [31:0]              rd_mux;
  logic                     err_mux;
  logic [NCTX*WORDS*32-1:0] en_words_q;

  assign acc       = req_valid && req_ready;
  assign req_ready = !rsp_valid || rsp_ready;

  intc_addr_decode #(
    .ADDR_W(ADDR_W), .NSRC(NSRC), .NCTX(NCTX),
    .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE),
    .EN_STRIDE(EN_STRIDE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) u_dec (
    .addr(req_addr),
    .dec (dec)
  );

  intc_reg_store #(
    .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .NUM_PRIO(NUM_PRIO), .TH_W(TH_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (acc && req_write),
    .dec       (dec),
    .wdata     (req_wdata),
    .prio_q    (prio_o),
    .en_words_q(en_words_q),
    .thr_q     (thr_o)
  );

  intc_read_mux #(
    .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .TH_W(TH_W), .ID_W(ID_W)
  ) u_rmux (
    .dec       (dec),
    .wr        (req_write),
    .prio_q    (prio_o),
    .en_words_q(en_words_q),
    .thr_q     (thr_o),
    .pend_i    (pend_i),
    .claim_id_i(claim_id_i),
    .rdata     (rd_mux),
    .err       (err_mux)
  );

  // strobes toward the arbiter, live in the accept cycle
  for (genvar c = 0; c < NCTX; c++) begin : g_strobe
    assign claim_o[c]    = acc && !req_write && dec.region == RG_CLAIM && dec.ctx == 16'(c);
    assign complete_o[c] = acc && req_write && dec.region == RG_CLAIM && dec.ctx == 16'(c)
                           && req_wdata >= 32'd1 && req_wdata <= 32'(NSRC);
    for (genvar s = 1; s <= NSRC; s++) begin : g_en_map
      assign en_o[c*NSRC + s - 1] = en_words_q[(c*WORDS + s/32)*32 + s%32];
    end
  end
  assign complete_id_o = req_wdata[ID_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
      rsp_err   <= err_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_reg_front_chk.sv
module intc_reg_front_chk #(
  parameter int          ADDR_W     = 24,
  parameter int          NCTX       = 2,
  parameter int          ID_W       = 6,
  parameter int          TH_W       = 3,
  parameter int unsigned NUM_PRIO   = 7,
  parameter int unsigned CTX_BASE   = 32'h10_0000,
  parameter int unsigned CTX_STRIDE = 32'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic [NCTX-1:0]   claim_o,
  input logic [NCTX-1:0]   complete_o,
  input logic [ID_W-1:0]   complete_id_o,
  input logic [NCTX*TH_W-1:0] thr_o
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  p_misalign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_addr[1:0] != 2'b00 |=> rsp_err && rsp_rdata == 32'd0);
  p_misalign_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_addr[1:0] != 2'b00 |-> claim_o == '0 && complete_o == '0);
  p_claim_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_o));
  p_claim_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    |claim_o |-> acc && !req_write);
  p_complete_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    |complete_o |-> acc && req_write && complete_id_o != '0);

  for (genvar c = 0; c < NCTX; c++) begin : g_thr
    p_thr_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_write && req_addr == ADDR_W'(CTX_BASE + c * CTX_STRIDE)
      && req_wdata > NUM_PRIO |=> $stable(thr_o[c*TH_W +: TH_W]));
  end
endmodule

bind intc_reg_front intc_reg_front_chk #(
  .ADDR_W(ADDR_W), .NCTX(NCTX), .ID_W(ID_W), .TH_W(TH_W), .NUM_PRIO(NUM_PRIO),
  .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .claim_o(claim_o), .complete_o(complete_o),
  .complete_id_o(complete_id_o), .thr_o(thr_o)
);

// File: tb/tb_intc_reg_front.sv
`timescale 1ns/1ps
module tb_intc_reg_front;
  localparam int AW = 24, NS = 40, NC = 2, PW = 3, IW = 6, TW = 3;
  localparam int unsigned NP = 7;
  localparam int unsigned PB = 32'h0000, DB = 32'h1000, EB = 32'h2000, ES = 32'h80;
  localparam int unsigned CB = 32'h10_0000, CS = 32'h1000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NS-1:0] pend_i;
  logic [NC*IW-1:0] claim_id_i;
  logic [NC-1:0] claim_o, complete_o;
  logic [IW-1:0] complete_id_o;
  logic [NS*PW-1:0] prio_o;
  logic [NC*NS-1:0] en_o;
  logic [NC*TW-1:0] thr_o;

  always #4 clk = ~clk;

  intc_reg_front #(
    .ADDR_W(AW), .NSRC(NS), .NCTX(NC), .PRIO_W(PW), .NUM_PRIO(NP),
    .PRIO_BASE(PB), .PEND_BASE(DB), .EN_BASE(EB), .EN_STRIDE(ES),
    .CTX_BASE(CB), .CTX_STRIDE(CS)
  ) dut (.*);

  // behavioural reference state
  int unsigned prio_m [NS+1];
  bit [31:0]   en_m   [NC][2];
  int unsigned thr_m  [NC];
  bit [63:0]   pend_m;
  int unsigned cid_m  [NC];
  int checks = 0, errors = 0;
  bit cmp_on = 0, finished = 0;

  assign pend_i     = pend_m[NS:1];
  assign claim_id_i = {IW'(cid_m[1]), IW'(cid_m[0])};

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // exported state compared with the model on every clock
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      logic [NS*PW-1:0] ep;
      logic [NC*NS-1:0] ee;
      logic [NC*TW-1:0] et;
      for (int s = 1; s <= NS; s++) ep[(s-1)*PW +: PW] = PW'(prio_m[s]);
      for (int c = 0; c < NC; c++) begin
        et[c*TW +: TW] = TW'(thr_m[c]);
        for (int s = 1; s <= NS; s++) ee[c*NS+s-1] = en_m[c][s/32][s%32];
      end
      chk(prio_o == ep, "R3", "prio_o", 128'(prio_o), 128'(ep));
      chk(en_o == ee,   "R6", "en_o",   128'(en_o),   128'(ee));
      chk(thr_o == et,  "R8", "thr_o",  128'(thr_o),  128'(et));
    end
  end

  task automatic model(input bit wr, input int unsigned a, input bit [31:0] wd, input bit upd,
                       output bit [31:0] rd, output bit er, output bit [NC-1:0] clm,
                       output bit [NC-1:0] cmp);
    int unsigned c, w;
    rd = 0; er = 0; clm = 0; cmp = 0;
    if (a % 4 != 0) er = 1;
    else if (a >= PB && a < PB + NS*4) begin
      if (wr) begin if (upd) prio_m[(a-PB)/4 + 1] = wd % 8; end
      else rd = prio_m[(a-PB)/4 + 1];
    end else if (a >= DB && a < DB + 8) begin
      if (wr) er = 1; else rd = pend_m[((a-DB)/4)*32 +: 32];
    end else if (a >= EB && a < EB + NC*ES) begin
      c = (a-EB)/ES; w = ((a-EB)%ES)/4;
      if (w >= 2) er = 1;
      else if (wr) begin
        if (upd) for (int b = 0; b < 32; b++)
          en_m[c][w][b] = wd[b] && (32*w+b >= 1) && (32*w+b <= NS);
      end else rd = en_m[c][w];
    end else if (a >= CB && a < CB + NC*CS) begin
      c = (a-CB)/CS; w = (a-CB)%CS;
      if (w == 0) begin
        if (wr) begin if (upd && wd <= NP) thr_m[c] = wd; end
        else rd = thr_m[c];
      end else if (w == 4) begin
        if (wr) begin if (wd >= 1 && wd <= NS) cmp[c] = 1; end
        else begin clm[c] = 1; rd = cid_m[c]; end
      end else er = 1;
    end else er = 1;
  endtask

  task automatic xact(input bit wr, input int unsigned a, input bit [31:0] wd, input string rq);
    bit [31:0] rd; bit er; bit [NC-1:0] clm, cmp;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = wd;
    model(wr, a, wd, 0, rd, er, clm, cmp);
    #1;
    chk(req_ready == 1, rq, "req_ready", 128'(req_ready), 1);
    chk(claim_o == clm, rq, "claim_o", 128'(claim_o), 128'(clm));
    chk(complete_o == cmp, rq, "complete_o", 128'(complete_o), 128'(cmp));
    if (cmp != 0) chk(complete_id_o == IW'(wd), rq, "complete_id", 128'(complete_id_o), 128'(wd));
    @(posedge clk);
    model(wr, a, wd, 1, rd, er, clm, cmp);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1, rq, "rsp_valid", 128'(rsp_valid), 1);
    chk(rsp_err == er, rq, "rsp_err", 128'(rsp_err), 128'(er));
    chk(rsp_rdata == rd, rq, "rsp_rdata", 128'(rsp_rdata), 128'(rd));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int s = 0; s <= NS; s++) prio_m[s] = 0;
    for (int c = 0; c < NC; c++) begin thr_m[c] = 0; en_m[c][0] = 0; en_m[c][1] = 0; end
    pend_m = 0; cid_m[0] = 5; cid_m[1] = 33;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(rsp_valid == 0, "R12", "rsp_valid", 128'(rsp_valid), 0);
    chk(req_ready == 1, "R12", "req_ready", 128'(req_ready), 1);
    chk(prio_o == 0 && en_o == 0 && thr_o == 0, "R12", "state", 128'(en_o), 0);
    cmp_on = 1;

    // R3 priority index offset and truncation
    xact(1, PB + 0, 32'hFFFF_FFFD, "R3");
    xact(0, PB + 0, 0, "R3");
    xact(1, PB + 39*4, 32'h3, "R3");
    xact(0, PB + 39*4, 0, "R3");
    xact(0, PB + 4, 0, "R3");
    // R4 pending view
    pend_m = 64'h0;
    pend_m[1] = 1; pend_m[31] = 1; pend_m[32] = 1; pend_m[40] = 1;
    xact(0, DB + 0, 0, "R4");
    xact(0, DB + 4, 0, "R4");
    // R5 pending is read-only
    xact(1, DB + 0, 32'hFFFF_FFFF, "R5");
    xact(0, DB + 0, 0, "R5");
    // R6 strided enables with masking
    xact(1, EB + 0, 32'hFFFF_FFFF, "R6");
    xact(1, EB + ES + 4, 32'hFFFF_FFFF, "R6");
    xact(0, EB + 0, 0, "R6");
    xact(0, EB + ES + 4, 0, "R6");
    xact(0, EB + ES, 0, "R6");
    // R7 enable word beyond the source span
    xact(1, EB + 8, 32'hFFFF_FFFF, "R7");
    xact(0, EB + ES + 8, 0, "R7");
    // R8 threshold range check
    xact(1, CB + CS, 7, "R8");
    xact(1, CB + CS, 8, "R8");
    xact(0, CB + CS, 0, "R8");
    xact(1, CB, 3, "R8");
    xact(1, CB, 32'h8000_0001, "R8");
    xact(0, CB, 0, "R8");
    // R9 claims
    xact(0, CB + 4, 0, "R9");
    xact(0, CB + CS + 4, 0, "R9");
    cid_m[0] = 40;
    xact(0, CB + 4, 0, "R9");
    // R10 completions
    xact(1, CB + CS + 4, 40, "R10");
    xact(1, CB + 4, 1, "R10");
    xact(1, CB + 4, 41, "R10");
    xact(1, CB + CS + 4, 0, "R10");
    // R2 misaligned
    xact(0, PB + 2, 0, "R2");
    xact(1, PB + 1, 32'h7, "R2");
    xact(1, CB + 5, 2, "R2");
    xact(0, PB + 0, 0, "R2");
    // R11 unmapped
    xact(0, 32'h8000, 0, "R11");
    xact(1, 32'h8000, 32'hFF, "R11");
    xact(0, CB + 8, 0, "R11");
    xact(0, CB + NC*CS, 0, "R11");

    // R1 back-pressure: response held, second request waits
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = AW'(PB); req_wdata = 0;
    @(posedge clk);
    @(negedge clk);
    req_write = 1; req_addr = AW'(PB + 4); req_wdata = 2;
    #1;
    chk(req_ready == 0, "R1", "req_ready stalled", 128'(req_ready), 0);
    chk(rsp_valid == 1 && rsp_rdata == 5, "R1", "held data", 128'(rsp_rdata), 5);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1 && rsp_rdata == 5 && rsp_err == 0, "R1", "still held", 128'(rsp_rdata), 5);
    rsp_ready = 1;
    #1;
    chk(req_ready == 1, "R1", "req_ready released", 128'(req_ready), 1);
    @(posedge clk);
    prio_m[2] = 2;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1 && rsp_err == 0 && rsp_rdata == 0, "R1", "second rsp", 128'(rsp_rdata), 0);
    @(negedge clk);
    chk(rsp_valid == 0, "R1", "rsp drained", 128'(rsp_valid), 0);
    xact(0, PB + 4, 0, "R1");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule